// File: doc/BRIEF.md
# External Data Bus Controller

This controller sits between an 8-bit microcontroller core and the core's on-chip data memories. It handles the core's indirect data moves. Each access gets a 16-bit address from one of two forms. The long form uses a 16-bit data pointer. The short form uses an 8-bit index register for the low byte and a separate page register for the high byte. The address is decoded into three sparse memory windows. The matching window's chip select and a read or write strobe are then driven for the whole access. A one-cycle done pulse ends the access.

Access length is counted in core clock cycles. It is one base cycle, plus a 3-bit software stretch value, plus fixed wait states for the selected window. The stretch value is held in the low bits of a clock-control register and resets to 1. An access to an address outside the three windows still takes its stretched time. No chip select or strobe is raised for it. A read of such an address returns 0xFF, and a write to it is discarded. Only one access runs at a time.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset the stretch value reads 1, and busy, done, all chip selects and both strobes are low.
- R2: A write to the clock-control register loads its bits [2:0] into the stretch value, which reads back on `stretch_q` from the next cycle. Bits [7:3] are ignored.
- R3: With `req_short`=1 the access address is {`page`,`idx`}. With `req_short`=0 it is `dptr`. The address appears on `mem_addr` for every cycle of the access.
- R4: Address 0x0000–0x07FF selects `cs_gen`, 0x1000–0x11FF selects `cs_ce`, and 0x2000–0x20FF selects `cs_cfg`. Every other address selects none. At most one chip select is high at a time.
- R5: An accepted access keeps `busy` high for exactly 1 + stretch + W cycles, where W is 0 for the general and configuration windows and 6 for the compute-engine window. `done` is high only in the last of those cycles.
- R6: A mapped read holds `rd_stb` high, and a mapped write holds `wr_stb` high, for every cycle of the access. `mem_addr` and `mem_wdata` stay constant across the access, and the two strobes are never high together.
- R7: In the done cycle of a mapped read, `rdata` equals the read data of the selected window.
- R8: An unmapped access raises no chip select and no strobe and still lasts 1 + stretch cycles. An unmapped read returns 0xFF on `rdata` in its done cycle.
- R9: A request seen while `busy` is high is ignored. The address, strobes and length of the running access do not change, and no access follows once the request is removed before the done cycle ends.
- R10: A write to the stretch value during an access does not change that access's length. It applies to the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, sampled while idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_short | input | 1 | 1 = page/index address form, 0 = data pointer form |
| dptr | input | 16 | 16-bit data pointer |
| idx | input | 8 | Index register (low address byte, short form) |
| page | input | 8 | Page register (high address byte, short form) |
| wdata | input | 8 | Write data |
| ckcon_we | input | 1 | Clock-control register write enable |
| ckcon_wdata | input | 8 | Clock-control register write value |
| gen_rdata | input | 8 | Read data from general data RAM |
| ce_rdata | input | 8 | Read data from compute-engine RAM |
| cfg_rdata | input | 8 | Read data from configuration RAM |
| stretch_q | output | 3 | Current stretch value |
| mem_addr | output | 16 | Latched access address |
| mem_wdata | output | 8 | Latched write data |
| cs_gen | output | 1 | General data RAM select |
| cs_ce | output | 1 | Compute-engine RAM select |
| cs_cfg | output | 1 | Configuration RAM select |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| busy | output | 1 | Access in progress |
| done | output | 1 | Last cycle of the access |
| rdata | output | 8 | Read result, valid while done |

## Verification
The assertions rely on the core keeping the request fields steady in the cycle when a request is accepted. They also assume that memory read data, which the block only passes through, is settled by the done cycle. The bench drives every input on the falling clock edge and models each window as a combinational function of `mem_addr`, so both assumptions always hold. Requests that arrive while busy are given different addresses and directions on purpose, which lets the hold-off and stability checks tell them apart from the running access.

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl #(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int SW          = 3,
  parameter int STRETCH_RST = 1,
  parameter int GEN_BASE    = 'h0000,
  parameter int GEN_SIZE    = 2048,
  parameter int GEN_WAIT    = 0,
  parameter int CE_BASE     = 'h1000,
  parameter int CE_SIZE     = 512,
  parameter int CE_WAIT     = 6,
  parameter int CFG_BASE    = 'h2000,
  parameter int CFG_SIZE    = 256,
  parameter int CFG_WAIT    = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic          req_short,
  input  logic [AW-1:0] dptr,
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] page,
  input  logic [DW-1:0] wdata,
  input  logic          ckcon_we,
  input  logic [7:0]    ckcon_wdata,
  input  logic [DW-1:0] gen_rdata,
  input  logic [DW-1:0] ce_rdata,
  input  logic [DW-1:0] cfg_rdata,
  output logic [SW-1:0] stretch_q,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          cs_gen,
  output logic          cs_ce,
  output logic          cs_cfg,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata
);

  localparam int MAXW   = (GEN_WAIT > CE_WAIT) ? ((GEN_WAIT > CFG_WAIT) ? GEN_WAIT : CFG_WAIT)
                                               : ((CE_WAIT > CFG_WAIT) ? CE_WAIT : CFG_WAIT);
  localparam int MAXCNT = (1 << SW) - 1 + MAXW;
  localparam int CW     = $clog2(MAXCNT + 1);

  function automatic logic in_win(input logic [AW-1:0] a, input int base, input int size);
    return (int'(a) >= base) && (int'(a) < base + size);
  endfunction

  logic [AW-1:0] req_addr;
  logic [2:0]    hit;
  logic [CW-1:0] wait_sel;
  logic [CW-1:0] cnt_q;
  logic [2:0]    sel_q;
  logic          wr_q;
  logic          busy_q;
  logic          mapped;
  logic          start;

  assign req_addr = req_short ? {page, idx} : dptr;
  assign hit[0]   = in_win(req_addr, GEN_BASE, GEN_SIZE);
  assign hit[1]   = in_win(req_addr, CE_BASE, CE_SIZE);
  assign hit[2]   = in_win(req_addr, CFG_BASE, CFG_SIZE);
  assign start    = req & ~busy_q;

  always_comb begin
    wait_sel = '0;
    if (hit[0])      wait_sel = CW'(GEN_WAIT);
    else if (hit[1]) wait_sel = CW'(CE_WAIT);
    else if (hit[2]) wait_sel = CW'(CFG_WAIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stretch_q <= SW'(STRETCH_RST);
    end else if (ckcon_we) begin
      stretch_q <= ckcon_wdata[SW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      sel_q     <= '0;
      wr_q      <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (start) begin
      busy_q    <= 1'b1;
      cnt_q     <= CW'(stretch_q) + wait_sel;
      sel_q     <= hit;
      wr_q      <= req_wr;
      mem_addr  <= req_addr;
      mem_wdata <= wdata;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign mapped = |sel_q;
  assign busy   = busy_q;
  assign done   = busy_q && (cnt_q == '0);
  assign cs_gen = busy_q & sel_q[0];
  assign cs_ce  = busy_q & sel_q[1];
  assign cs_cfg = busy_q & sel_q[2];
  assign rd_stb = busy_q & mapped & ~wr_q;
  assign wr_stb = busy_q & mapped & wr_q;

  always_comb begin
    rdata = '0;
    if (done) begin
      if (sel_q[0])      rdata = gen_rdata;
      else if (sel_q[1]) rdata = ce_rdata;
      else if (sel_q[2]) rdata = cfg_rdata;
      else               rdata = '1;
    end
  end

endmodule

module xmem_bus_ctrl_chk #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int CE_BASE = 'h1000,
  parameter int CE_SIZE = 512,
  parameter int MAXLEN  = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          cs_gen,
  input logic          cs_ce,
  input logic          cs_cfg,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);

  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || done) run_len <= 0;
    else                         run_len <= run_len + 1;
  end

  assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_gen, cs_ce, cs_cfg}));

  assert_ce_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_ce |-> (int'(mem_addr) >= CE_BASE) && (int'(mem_addr) < CE_BASE + CE_SIZE));

  assert_done_in_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < MAXLEN);

  assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mem_addr) && $stable(mem_wdata));

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  assert_strobe_mapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (cs_gen || cs_ce || cs_cfg));

endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(.AW(AW), .DW(DW), .CE_BASE(CE_BASE), .CE_SIZE(CE_SIZE),
                                       .MAXLEN(MAXCNT + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cs_gen(cs_gen), .cs_ce(cs_ce),
  .cs_cfg(cs_cfg), .rd_stb(rd_stb), .wr_stb(wr_stb), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/sim_xmem_bus_ctrl.sv
`timescale 1ns/1ps
module sim_xmem_bus_ctrl;
  logic clk = 0;
  logic rst_n = 0;
  logic req = 0, req_wr = 0, req_short = 0;
  logic [15:0] dptr = 0;
  logic [7:0] idx = 0, page = 0, wdata = 0;
  logic ckcon_we = 0;
  logic [7:0] ckcon_wdata = 0;
  logic [7:0] gen_rdata, ce_rdata, cfg_rdata;
  logic [2:0] stretch_q;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, rdata;
  logic cs_gen, cs_ce, cs_cfg, rd_stb, wr_stb, busy, done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign gen_rdata = mem_addr[7:0] ^ 8'h3C;
  assign ce_rdata  = mem_addr[7:0] + 8'h11;
  assign cfg_rdata = ~mem_addr[7:0];

  xmem_bus_ctrl u0 (.*);

  function automatic int region(input logic [15:0] a);
    if (a <= 16'h07FF) return 0;
    if (a >= 16'h1000 && a <= 16'h11FF) return 1;
    if (a >= 16'h2000 && a <= 16'h20FF) return 2;
    return 3;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    case (region(a))
      0: return a[7:0] ^ 8'h3C;
      1: return a[7:0] + 8'h11;
      2: return ~a[7:0];
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic set_stretch(input int st);
    @(negedge clk);
    ckcon_we = 1; ckcon_wdata = {5'b10101, 3'(st)};
    @(negedge clk);
    ckcon_we = 0;
    check(stretch_q == 3'(st), "R2 stretch readback", stretch_q, st);
  endtask

  task automatic run_acc(input bit wr, input bit sh, input logic [15:0] a,
                         input logic [7:0] wd, input int st);
    int rg = region(a);
    int exp_len = 1 + st + ((rg == 1) ? 6 : 0);
    int len = 0;
    bit ok_cs = 1, ok_stb = 1, ok_adr = 1;
    logic [7:0] got = 0;
    @(negedge clk);
    req_wr = wr; req_short = sh; wdata = wd;
    if (sh) begin page = a[15:8]; idx = a[7:0]; dptr = ~a; end
    else    begin dptr = a; page = ~a[15:8]; idx = ~a[7:0]; end
    req = 1;
    @(negedge clk);
    req = 0;
    forever begin
      len++;
      if (!busy) ok_adr = 0;
      if ({cs_cfg, cs_ce, cs_gen} != ((rg == 3) ? 3'b000 : 3'(1 << rg))) ok_cs = 0;
      if (rd_stb != (!wr && rg != 3) || wr_stb != (wr && rg != 3)) ok_stb = 0;
      if (mem_addr != a || (wr && mem_wdata != wd)) ok_adr = 0;
      if (done || len > 20) begin got = rdata; break; end
      @(negedge clk);
    end
    check(ok_adr, "R3 address form", mem_addr, a);
    check(ok_cs, "R4 chip select", {cs_cfg, cs_ce, cs_gen}, rg);
    check(ok_stb, "R6 strobes", {wr_stb, rd_stb}, wr);
    check(len == exp_len, "R5 access length", len, exp_len);
    if (!wr) check(got == exp_rd(a), (rg == 3) ? "R8 unmapped read" : "R7 read data",
                   got, exp_rd(a));
    @(negedge clk);
    check(!busy && !done, "R5 idle after done", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] edges [11] = '{16'h07FF, 16'h0800, 16'h0FFF, 16'h1000, 16'h11FF, 16'h1200,
                                16'h1FFF, 16'h2000, 16'h20FF, 16'h2100, 16'hFFFF};
    logic [15:0] reps [4] = '{16'h0123, 16'h1155, 16'h2077, 16'h8000};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(stretch_q == 3'd1, "R1 reset stretch", stretch_q, 1);
    check({busy, done, cs_gen, cs_ce, cs_cfg, rd_stb, wr_stb} == 0, "R1 reset outputs",
          {busy, done, cs_gen, cs_ce, cs_cfg, rd_stb, wr_stb}, 0);
    run_acc(0, 0, 16'h0042, 8'h00, 1);

    for (int st = 0; st < 8; st++) begin
      set_stretch(st);
      for (int r = 0; r < 4; r++)
        for (int m = 0; m < 4; m++)
          run_acc(m[0], m[1], reps[r] + 16'(st * 3 + m), 8'(st * 16 + r * 4 + m), st);
    end

    set_stretch(1);
    for (int i = 0; i < 11; i++) begin
      run_acc(0, i[0], edges[i], 8'h00, 1);
      run_acc(1, ~i[0], edges[i], 8'(i), 1);
    end

    // R9: a second request while busy must be ignored
    set_stretch(3);
    begin
      int len = 0;
      bit ok = 1;
      @(negedge clk);
      req_wr = 0; req_short = 0; dptr = 16'h1010; req = 1;
      @(negedge clk);
      req = 0;
      forever begin
        len++;
        if (len == 3) begin req = 1; req_wr = 1; dptr = 16'h0005; wdata = 8'hA5; end
        if (mem_addr != 16'h1010 || wr_stb || !cs_ce) ok = 0;
        if (done || len > 20) break;
        @(negedge clk);
      end
      req = 0;
      check(ok, "R9 held-off request", mem_addr, 16'h1010);
      check(len == 10, "R9 length unchanged", len, 10);
      @(negedge clk);
      check(!busy && !cs_gen && !wr_stb, "R9 no follow-on access", busy, 0);
    end

    // R10: stretch change mid-access
    set_stretch(2);
    begin
      int len = 0;
      @(negedge clk);
      req_wr = 0; req_short = 1; page = 8'h11; idx = 8'h80; req = 1;
      @(negedge clk);
      req = 0;
      forever begin
        len++;
        ckcon_we = (len == 2); ckcon_wdata = 8'h07;
        if (done || len > 20) break;
        @(negedge clk);
      end
      ckcon_we = 0;
      check(len == 9, "R10 in-flight length", len, 9);
      @(negedge clk);
      check(stretch_q == 3'd7, "R10 new stretch", stretch_q, 7);
    end
    run_acc(0, 0, 16'h1001, 8'h00, 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule